// File: doc/BRIEF.md
# Third-Order Sigma-Delta Divide-Ratio Sequencer

This block produces the integer divide value for a fractional-N feedback divider on every phase-detector cycle. It takes a 12-bit integer word and a 25-bit fraction word, and emits a sequence of integer ratios whose long-run average is the integer word plus the fraction over 2^25. The modulus is a fixed power of two and cannot be programmed. On each strobe the value is the integer word plus a small signed offset, and that offset comes from a third-order noise shaper built as three cascaded 25-bit accumulators.

New words are written with a load strobe. They are held in pending registers and take effect on the next cycle strobe, so a divide value never mixes old and new settings. By default, applying a newly written word pair also clears the modulator state. A keep-state input taken with the write suppresses that clear. Integer words below the prescaler's floor are raised to the floor: 23 in the narrow prescaler mode and 75 in the wide mode.

Top module: `sdm_frac_divider`

## Requirements
- R1: After reset, `div_out` is 0. The modulator state and the pending and active words are all zero.
- R2: `div_out` changes only on a clock edge where `step` is high. It holds its value on every other cycle.
- R3: With a fraction of 0, every step outputs exactly the effective integer word.
- R4: Over 4096 consecutive steps that start from a cleared state, the sum of outputs is within ±4 of 4096·INT + floor(FRAC/2^13). In other words, the mean equals INT + FRAC/2^25.
- R5: Every output of a running (non-clearing) step lies within the effective integer −3 to +4.
- R6: The effective integer is max(int_word, floor). The floor is 23 when `wide_presc`=0 and 75 when `wide_presc`=1, and `wide_presc` is read at the step.
- R7: Words written with `load` do not affect `div_out` until the next `step`. If several loads happen before that step, the last one is used.
- R8: A step that applies a load made with `keep_state`=0 zeroes all three accumulators and the carry history, and outputs exactly the effective integer. The output sequence that follows is identical each time the same words are applied this way.
- R9: A load made with `keep_state`=1 leaves the modulator state untouched. Reapplying the same words this way mid-run gives the same 4096-step output sum as an uninterrupted run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One-cycle strobe per phase-detector cycle |
| load | input | 1 | Write strobe for the integer/fraction words |
| keep_state | input | 1 | Sampled with `load`; 1 suppresses the modulator clear |
| wide_presc | input | 1 | Prescaler mode: 0 gives floor 23, 1 gives floor 75 |
| int_word | input | 12 | Integer part of the division ratio |
| frac_word | input | 25 | Fraction numerator over 2^25 |
| div_out | output | 13 | Registered divide value for the current cycle |

## Verification
Four properties are checked on every cycle. The output holds between strobes. Each running output stays inside the −3..+4 window around the effective integer. No output falls more than 3 below the prescaler floor. A clearing step produces exactly the integer and leaves every accumulator at zero. The bench scenarios cover what only a sequence can show: the long-run mean of 4096 outputs for several word pairs, the constant output for a zero fraction, the deferral of writes, the repeatability after a clear, and the continuity of the state across a keep-state write.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef logic signed [3:0] sd_ofs_t;

  // Third-order carry recombination: c1 + (c2 - c2') + (c3 - 2c3' + c3'')
  function automatic sd_ofs_t mash_offset(input logic c1, input logic c2,
                                          input logic c2_prev, input logic c3,
                                          input logic c3_prev, input logic c3_prev2);
    logic [3:0] raw;
    raw = {3'b000, c1} + {3'b000, c2} - {3'b000, c2_prev}
        + {3'b000, c3} - {2'b00, c3_prev, 1'b0} + {3'b000, c3_prev2};
    return sd_ofs_t'(raw);
  endfunction
endpackage

// File: rtl/sdm_accum.sv
module sdm_accum #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum_next,
  output logic         carry
);
  logic [W-1:0] acc_q;
  logic [W:0]   wide_sum;

  assign wide_sum = {1'b0, acc_q} + {1'b0, addend};
  assign sum_next = wide_sum[W-1:0];
  assign carry    = wide_sum[W];

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (adv) acc_q <= clr ? '0 : sum_next;
  end
endmodule

// File: rtl/sdm_noise_shaper.sv
module sdm_noise_shaper
  import sdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       clr,
  input  logic [2:0] carries,
  output sd_ofs_t    offset
);
  logic c2_d1, c3_d1, c3_d2;

  assign offset = mash_offset(carries[0], carries[1], c2_d1,
                              carries[2], c3_d1, c3_d2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c2_d1 <= 1'b0; c3_d1 <= 1'b0; c3_d2 <= 1'b0;
    end else if (adv) begin
      if (clr) begin
        c2_d1 <= 1'b0; c3_d1 <= 1'b0; c3_d2 <= 1'b0;
      end else begin
        c2_d1 <= carries[1];
        c3_d1 <= carries[2];
        c3_d2 <= c3_d1;
      end
    end
  end
endmodule

// File: rtl/sdm_frac_divider.sv
module sdm_frac_divider
  import sdm_pkg::*;
#(
  parameter int INT_W      = 12,
  parameter int FRAC_W     = 25,
  parameter int MIN_NARROW = 23,
  parameter int MIN_WIDE   = 75
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic              keep_state,
  input  logic              wide_presc,
  input  logic [INT_W-1:0]  int_word,
  input  logic [FRAC_W-1:0] frac_word,
  output logic [INT_W:0]    div_out
);
  localparam int OUT_W  = INT_W + 1;
  localparam int STAGES = 3;

  function automatic logic [INT_W-1:0] apply_floor(input logic [INT_W-1:0] v,
                                                   input logic wide);
    logic [INT_W-1:0] lim;
    lim = wide ? INT_W'(MIN_WIDE) : INT_W'(MIN_NARROW);
    return (v < lim) ? lim : v;
  endfunction

  logic [INT_W-1:0]  pend_int, act_int, int_use, int_eff;
  logic [FRAC_W-1:0] pend_frac, act_frac, frac_use;
  logic              pend_valid, pend_clr, clr_now;
  logic [FRAC_W-1:0] chain [STAGES+1];
  logic [STAGES-1:0] carries;
  sd_ofs_t           offset;
  logic [OUT_W-1:0]  run_value;

  // Pending words wait for the next cycle strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_int <= '0; pend_frac <= '0; pend_valid <= 1'b0; pend_clr <= 1'b0;
      act_int  <= '0; act_frac  <= '0;
    end else begin
      if (load) begin
        pend_int   <= int_word;
        pend_frac  <= frac_word;
        pend_valid <= 1'b1;
        pend_clr   <= !keep_state;
      end else if (step) begin
        pend_valid <= 1'b0;
        pend_clr   <= 1'b0;
      end
      if (step && pend_valid) begin
        act_int  <= pend_int;
        act_frac <= pend_frac;
      end
    end
  end

  assign int_use  = pend_valid ? pend_int  : act_int;
  assign frac_use = pend_valid ? pend_frac : act_frac;
  assign int_eff  = apply_floor(int_use, wide_presc);
  assign clr_now  = step && pend_valid && pend_clr;
  assign chain[0] = frac_use;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    sdm_accum #(.W(FRAC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .adv(step), .clr(clr_now),
      .addend(chain[g]), .sum_next(chain[g+1]), .carry(carries[g])
    );
  end

  sdm_noise_shaper u_shaper (
    .clk(clk), .rst_n(rst_n), .adv(step), .clr(clr_now),
    .carries(carries), .offset(offset)
  );

  assign run_value = {1'b0, int_eff} + {{(OUT_W-4){offset[3]}}, offset};

  always_ff @(posedge clk) begin
    if (!rst_n)    div_out <= '0;
    else if (step) div_out <= clr_now ? {1'b0, int_eff} : run_value;
  end

  assert_step_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(div_out));

  assert_offset_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr_now) |=> ((div_out + 13'd3 >= {1'b0, $past(int_eff)}) &&
                            (div_out <= {1'b0, $past(int_eff)} + 13'd4)));

  assert_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (div_out + 13'd3 >= ($past(wide_presc) ? 13'(MIN_WIDE) : 13'(MIN_NARROW))));

  assert_clear_exact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (div_out == {1'b0, $past(int_eff)}));

  assert_stages_zeroed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && !load) |=> (chain[STAGES] == chain[1]));
endmodule

// File: tb/sdm_frac_divider_test.sv
module sdm_frac_divider_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0, load = 1'b0, keep_state = 1'b0, wide_presc = 1'b0;
  logic [11:0] int_word = '0;
  logic [24:0] frac_word = '0;
  logic [12:0] div_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdm_frac_divider uut (
    .clk(clk), .rst_n(rst_n), .step(step), .load(load), .keep_state(keep_state),
    .wide_presc(wide_presc), .int_word(int_word), .frac_word(frac_word),
    .div_out(div_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_step(output int v);
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
    v = int'(div_out);
  endtask

  task automatic write_words(input int iv, input int fv, input bit keep);
    @(negedge clk);
    load = 1'b1; int_word = 12'(iv); frac_word = 25'(fv); keep_state = keep;
    @(negedge clk);
    load = 1'b0; keep_state = 1'b0;
  endtask

  task automatic t_reset;
    check(div_out == 13'd0, "R1 reset output", int'(div_out), 0);
  endtask

  task automatic t_zero_frac;
    int v;
    bit ok = 1'b1;
    int last = 0;
    write_words(100, 0, 1'b0);
    for (int k = 0; k < 32; k++) begin
      do_step(v);
      if (v != 100) begin ok = 1'b0; last = v; end
    end
    check(ok, "R3 zero fraction constant", last, 100);
  endtask

  task automatic t_floor;
    int v;
    write_words(10, 0, 1'b0);
    do_step(v); check(v == 23, "R6 narrow floor", v, 23);
    @(negedge clk) wide_presc = 1'b1;
    do_step(v); check(v == 75, "R6 wide floor", v, 75);
    write_words(50, 0, 1'b0);
    do_step(v); check(v == 75, "R6 wide floor raises 50", v, 75);
    @(negedge clk) wide_presc = 1'b0;
    do_step(v); check(v == 50, "R6 narrow passes 50", v, 50);
  endtask

  task automatic t_mean(input int iv, input int fv);
    int v, sum, exp_sum, lo_bad, first;
    bit win_ok = 1'b1;
    sum = 0; lo_bad = 0;
    write_words(iv, fv, 1'b0);
    for (int k = 0; k < 4096; k++) begin
      do_step(v);
      if (k == 0) first = v;
      else if (v < iv - 3 || v > iv + 4) begin win_ok = 1'b0; lo_bad = v; end
      sum += v;
    end
    exp_sum = 4096 * iv + (fv >>> 13);
    check(first == iv, "R8 clearing step gives integer", first, iv);
    check(win_ok, "R5 offset window", lo_bad, iv);
    check(sum >= exp_sum - 4 && sum <= exp_sum + 4, "R4 mean of 4096 outputs", sum, exp_sum);
  endtask

  task automatic t_deferred;
    int v;
    write_words(300, 0, 1'b0);
    do_step(v);
    write_words(400, 0, 1'b0);
    repeat (5) @(negedge clk);
    check(div_out == 13'd300, "R7 load deferred until step", int'(div_out), 300);
    check(div_out == 13'd300, "R2 idle cycles hold output", int'(div_out), 300);
    write_words(500, 0, 1'b0);
    do_step(v);
    check(v == 500, "R7 last load wins", v, 500);
  endtask

  task automatic t_clear_repeat;
    int a [16];
    int v;
    bit same = 1'b1;
    int diff_at = -1;
    write_words(700, 5555555, 1'b0);
    for (int k = 0; k < 16; k++) begin do_step(v); a[k] = v; end
    for (int k = 0; k < 10; k++) do_step(v);
    write_words(700, 5555555, 1'b0);
    for (int k = 0; k < 16; k++) begin
      do_step(v);
      if (v != a[k] && same) begin same = 1'b0; diff_at = k; end
    end
    check(same, "R8 sequence repeats after clear", diff_at, -1);
  endtask

  task automatic t_keep;
    int v, sum_a, sum_b;
    sum_a = 0; sum_b = 0;
    write_words(900, 7777777, 1'b0);
    for (int k = 0; k < 4096; k++) begin do_step(v); sum_a += v; end
    write_words(900, 7777777, 1'b0);
    for (int k = 0; k < 2048; k++) begin do_step(v); sum_b += v; end
    write_words(900, 7777777, 1'b1);
    for (int k = 0; k < 2048; k++) begin do_step(v); sum_b += v; end
    check(sum_a == sum_b, "R9 keep-state write continues modulator", sum_b, sum_a);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_zero_frac;
    t_floor;
    t_mean(200, 1);
    t_mean(200, 1 << 24);
    t_mean(4095, (1 << 25) - 1);
    t_mean(1000, 12345678);
    t_mean(23, 3000001);
    t_deferred;
    t_clear_repeat;
    t_keep;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule